// File: doc/BRIEF.md
# Multiplexed Component Video Input Demultiplexer

This block takes a 10-bit component video word stream and splits it into four parallel channels: luma, blue and red colour difference, and key. It has three input modes. In the dual-link multiplexed mode, two ports each carry a four-word group. In the single-link multiplexed mode, one port carries every word at twice the dual-link word rate. In the non-multiplexed mode, each channel arrives on its own port in every cycle. The two mode bits are decoded at the edge of the block.

A chroma-sync strobe sets the word-phase counter. Its high-to-low transition marks the word that begins a group, which must be an even-numbered blue-difference sample. The counter then runs freely while the strobe stays low. The next high-to-low transition realigns it. Nothing is produced between reset and the first such transition.

A blanking stage follows the demultiplexer. When blanking is requested on the word that completes a pixel, every channel of that pixel is replaced by a programmable level. A flag marks whether the chroma of each output pixel was really sampled at that pixel or was carried over from the previous sample.

Top module: `video_demux`

## Requirements
- R1: Mode decode: `par_in`=1 selects non-multiplexed input, whatever the value of `one_link`. With `par_in`=0, `one_link`=0 selects dual-link input and `one_link`=1 selects single-link input.
- R2: After reset `out_valid` is 0 and every channel output is 0. Words that arrive before the first high-to-low transition of `cb_sync` after reset are discarded, and `out_valid` stays 0 until that transition.
- R3: Dual link: the word that carries the transition is phase 0. Port A carries Cb, Y0, Cr, Y1 at phases 0 to 3. Port B carries Cb', K0, Cr', K1. The cycle after the phase-2 word, the outputs show {Y0, Cb, Cr, K0} with `out_cosited`=1 and `out_valid`=1.
- R4: Dual link, second pixel: the cycle after the phase-3 word, the outputs show Y1 and K1. When `full_chroma`=0 they also show the stored Cb and Cr, with `out_cosited`=0. When `full_chroma`=1 they show Cb' and Cr', with `out_cosited`=1.
- R5: Single link: port A carries Cb, Y, Cr, K at phases 0 to 3. One pixel is produced per group, the cycle after the phase-3 word, with `out_cosited`=1. `out_valid` is 0 in the other cycles.
- R6: Non-multiplexed: ports A, B, C and D carry Y, Cb, Cr and K, and a pixel is produced in every cycle once aligned. The aligning word is an even sample, and the samples then alternate. An odd sample with `full_chroma`=0 takes the chroma of the preceding even sample and has `out_cosited`=0. An odd sample with `full_chroma`=1 takes its own chroma and has `out_cosited`=1.
- R7: While `cb_sync` stays low, the phase keeps advancing across groups. A new high-to-low transition resets the phase to 0 on that word, wherever the old count stood.
- R8: If `blank_req`=1 on the word that completes a pixel, all four channel outputs of that pixel equal the blanking levels. If `blank_req`=0 on that word, the data passes unchanged. `out_cosited` is unaffected either way.
- R9: The blanking levels reset to 64 (Y), 512 (Cb), 512 (Cr) and 64 (K). `lvl_we`=1 loads `lvl_y`, `lvl_cb`, `lvl_cr` and `lvl_k` at that clock edge. A pixel blanked in the same cycle as a load still uses the previous levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_in | input | 1 | 1 = non-multiplexed input |
| one_link | input | 1 | With par_in=0: 1 = single link, 0 = dual link |
| full_chroma | input | 1 | 1 = every pixel carries its own chroma |
| cb_sync | input | 1 | Chroma-sync strobe; a falling transition aligns the phase |
| blank_req | input | 1 | Horizontal blanking request |
| din_a | input | 10 | Port A word (link A, single link, or Y) |
| din_b | input | 10 | Port B word (link B or Cb) |
| din_c | input | 10 | Port C word (Cr, non-multiplexed only) |
| din_d | input | 10 | Port D word (K, non-multiplexed only) |
| lvl_we | input | 1 | Load the blanking levels |
| lvl_y | input | 10 | New luma blanking level |
| lvl_cb | input | 10 | New Cb blanking level |
| lvl_cr | input | 10 | New Cr blanking level |
| lvl_k | input | 10 | New key blanking level |
| out_valid | output | 1 | A pixel is presented this cycle |
| out_y | output | 10 | Luma channel |
| out_cb | output | 10 | Cb channel |
| out_cr | output | 10 | Cr channel |
| out_k | output | 10 | Key channel |
| out_cosited | output | 1 | 1 = chroma sampled at this pixel |

## Verification
A blanking level load and a blanked pixel can fall on the same cycle. The bench drives `lvl_we` together with `blank_req` on the word that completes a pixel. It expects the old default levels on that pixel and the new levels on the next blanked pixel. A realigning sync transition can also arrive while the old count is mid-group. The bench starts a new group one word early and judges the case by the absence of the pixel the old phase would have produced, followed by the first pixel of the new group.

// File: rtl/vdmx_pkg.sv
package vdmx_pkg;

   typedef enum logic [1:0] {
      MODE_DUAL   = 2'd0,
      MODE_SINGLE = 2'd1,
      MODE_PAR    = 2'd2
   } in_mode_e;

   // par_in dominates; one_link only chooses between the two multiplexed forms
   function automatic in_mode_e decode_mode(input logic par_in, input logic one_link);
      if (par_in)
         return MODE_PAR;
      else if (one_link)
         return MODE_SINGLE;
      else
         return MODE_DUAL;
   endfunction

endpackage

// File: rtl/vdmx_sync_align.sv
module vdmx_sync_align #(
   parameter int PHW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cb_sync,
   input  logic           wrap_two,
   output logic [PHW-1:0] phase_now,
   output logic           locked_now,
   output logic           lock_q,
   output logic           fall
);
   logic           sync_d;
   logic [PHW-1:0] phase_q;
   logic [PHW-1:0] phase_nx;

   generate
      if (PHW < 2) begin : g_bad_phw
         $error("vdmx_sync_align: PHW must be at least 2");
      end
   endgenerate

   assign fall       = sync_d & ~cb_sync;
   assign phase_now  = fall ? '0 : phase_q;
   assign locked_now = lock_q | fall;

   always_comb begin
      phase_nx = phase_q;
      if (locked_now) begin
         if (wrap_two)
            phase_nx = {{(PHW-1){1'b0}}, ~phase_now[0]};
         else
            phase_nx = phase_now + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_d  <= 1'b0;
         phase_q <= '0;
         lock_q  <= 1'b0;
      end else begin
         sync_d  <= cb_sync;
         phase_q <= phase_nx;
         if (fall)
            lock_q <= 1'b1;
      end
   end

   // R7: the word after a falling sync edge is always phase 1
   a_r7_realign: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> (phase_q == PHW'(1)));

   // R2: once aligned, the lock is kept until reset
   a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);

endmodule

// File: rtl/vdmx_word_demux.sv
module vdmx_word_demux
   import vdmx_pkg::*;
#(
   parameter int W   = 10,
   parameter int PHW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  in_mode_e       mode,
   input  logic           full_chroma,
   input  logic [PHW-1:0] phase_now,
   input  logic           locked_now,
   input  logic [W-1:0]   din_a,
   input  logic [W-1:0]   din_b,
   input  logic [W-1:0]   din_c,
   input  logic [W-1:0]   din_d,
   output logic           emit,
   output logic [W-1:0]   pix_y,
   output logic [W-1:0]   pix_cb,
   output logic [W-1:0]   pix_cr,
   output logic [W-1:0]   pix_k,
   output logic           pix_cos
);
   typedef struct packed {
      logic [W-1:0] cb_a;
      logic [W-1:0] cb_b;
      logic [W-1:0] cr_a;
      logic [W-1:0] cr_b;
      logic [W-1:0] y0;
      logic [W-1:0] k0;
   } hold_t;

   hold_t hold_q, hold_nx;

   always_comb begin
      hold_nx = hold_q;
      emit    = 1'b0;
      pix_y   = '0;
      pix_cb  = '0;
      pix_cr  = '0;
      pix_k   = '0;
      pix_cos = 1'b0;
      if (locked_now) begin
         case (mode)
            MODE_DUAL: begin
               case (phase_now)
                  PHW'(0): begin
                     hold_nx.cb_a = din_a;
                     hold_nx.cb_b = din_b;
                  end
                  PHW'(1): begin
                     hold_nx.y0 = din_a;
                     hold_nx.k0 = din_b;
                  end
                  PHW'(2): begin
                     hold_nx.cr_a = din_a;
                     hold_nx.cr_b = din_b;
                     emit    = 1'b1;
                     pix_y   = hold_q.y0;
                     pix_cb  = hold_q.cb_a;
                     pix_cr  = din_a;
                     pix_k   = hold_q.k0;
                     pix_cos = 1'b1;
                  end
                  default: begin
                     emit    = 1'b1;
                     pix_y   = din_a;
                     pix_k   = din_b;
                     pix_cb  = full_chroma ? hold_q.cb_b : hold_q.cb_a;
                     pix_cr  = full_chroma ? hold_q.cr_b : hold_q.cr_a;
                     pix_cos = full_chroma;
                  end
               endcase
            end
            MODE_SINGLE: begin
               case (phase_now)
                  PHW'(0): hold_nx.cb_a = din_a;
                  PHW'(1): hold_nx.y0   = din_a;
                  PHW'(2): hold_nx.cr_a = din_a;
                  default: begin
                     emit    = 1'b1;
                     pix_y   = hold_q.y0;
                     pix_cb  = hold_q.cb_a;
                     pix_cr  = hold_q.cr_a;
                     pix_k   = din_a;
                     pix_cos = 1'b1;
                  end
               endcase
            end
            default: begin
               emit  = 1'b1;
               pix_y = din_a;
               pix_k = din_d;
               if (!phase_now[0]) begin
                  hold_nx.cb_a = din_b;
                  hold_nx.cr_a = din_c;
                  pix_cb  = din_b;
                  pix_cr  = din_c;
                  pix_cos = 1'b1;
               end else begin
                  pix_cb  = full_chroma ? din_b : hold_q.cb_a;
                  pix_cr  = full_chroma ? din_c : hold_q.cr_a;
                  pix_cos = full_chroma;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         hold_q <= '0;
      else
         hold_q <= hold_nx;
   end

   // R5: single link yields at most one pixel per group, never two in a row
   a_r5_single_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_SINGLE && emit) |=> !(mode == MODE_SINGLE && emit));

   // R4: a carried-over chroma pixel in dual link only ever closes a group
   a_r4_split: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_DUAL && emit && !pix_cos) |-> (phase_now == PHW'(3)));

   // R6: non-multiplexed input yields a pixel in every aligned cycle
   a_r6_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_PAR && locked_now) |-> emit);

endmodule

// File: rtl/vdmx_blank_chan.sv
module vdmx_blank_chan #(
   parameter int W   = 10,
   parameter int DEF = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         blank,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic [W-1:0] level
);
   generate
      if (DEF < 0 || DEF >= (1 << W)) begin : g_bad_def
         $error("vdmx_blank_chan: DEF does not fit in W bits");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         level <= W'(DEF);
      else if (ld)
         level <= ld_val;
   end

   assign dout = blank ? level : din;

endmodule

// File: rtl/video_demux.sv
module video_demux
   import vdmx_pkg::*;
#(
   parameter int W            = 10,
   parameter int BLANK_LUMA   = 64,
   parameter int BLANK_CHROMA = 512,
   parameter int BLANK_KEY    = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         par_in,
   input  logic         one_link,
   input  logic         full_chroma,
   input  logic         cb_sync,
   input  logic         blank_req,
   input  logic [W-1:0] din_a,
   input  logic [W-1:0] din_b,
   input  logic [W-1:0] din_c,
   input  logic [W-1:0] din_d,
   input  logic         lvl_we,
   input  logic [W-1:0] lvl_y,
   input  logic [W-1:0] lvl_cb,
   input  logic [W-1:0] lvl_cr,
   input  logic [W-1:0] lvl_k,
   output logic         out_valid,
   output logic [W-1:0] out_y,
   output logic [W-1:0] out_cb,
   output logic [W-1:0] out_cr,
   output logic [W-1:0] out_k,
   output logic         out_cosited
);
   localparam int PHW   = 2;
   localparam int NCHAN = 4;

   generate
      if (W < 8 || W > 16) begin : g_bad_w
         $error("video_demux: W must lie between 8 and 16");
      end
   endgenerate

   in_mode_e       mode;
   logic [PHW-1:0] phase_now;
   logic           locked_now, lock_q, fall;
   logic           emit, pix_cos;
   logic [W-1:0]   pix_y, pix_cb, pix_cr, pix_k;
   logic [W-1:0]   raw_ch [NCHAN];
   logic [W-1:0]   new_ch [NCHAN];
   logic [W-1:0]   blk_ch [NCHAN];
   logic [W-1:0]   lvl_ch [NCHAN];

   assign mode = decode_mode(par_in, one_link);

   vdmx_sync_align #(.PHW(PHW)) u_align (
      .clk       (clk),
      .rst_n     (rst_n),
      .cb_sync   (cb_sync),
      .wrap_two  (mode == MODE_PAR),
      .phase_now (phase_now),
      .locked_now(locked_now),
      .lock_q    (lock_q),
      .fall      (fall)
   );

   vdmx_word_demux #(.W(W), .PHW(PHW)) u_demux (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .full_chroma(full_chroma),
      .phase_now  (phase_now),
      .locked_now (locked_now),
      .din_a      (din_a),
      .din_b      (din_b),
      .din_c      (din_c),
      .din_d      (din_d),
      .emit       (emit),
      .pix_y      (pix_y),
      .pix_cb     (pix_cb),
      .pix_cr     (pix_cr),
      .pix_k      (pix_k),
      .pix_cos    (pix_cos)
   );

   assign raw_ch[0] = pix_y;
   assign raw_ch[1] = pix_cb;
   assign raw_ch[2] = pix_cr;
   assign raw_ch[3] = pix_k;
   assign new_ch[0] = lvl_y;
   assign new_ch[1] = lvl_cb;
   assign new_ch[2] = lvl_cr;
   assign new_ch[3] = lvl_k;

   generate
      for (genvar i = 0; i < NCHAN; i++) begin : g_blank
         localparam int DEF = (i == 0) ? BLANK_LUMA :
                              (i == 3) ? BLANK_KEY  : BLANK_CHROMA;
         vdmx_blank_chan #(.W(W), .DEF(DEF)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .ld    (lvl_we),
            .ld_val(new_ch[i]),
            .blank (blank_req),
            .din   (raw_ch[i]),
            .dout  (blk_ch[i]),
            .level (lvl_ch[i])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_y       <= '0;
         out_cb      <= '0;
         out_cr      <= '0;
         out_k       <= '0;
         out_cosited <= 1'b0;
      end else begin
         out_valid <= emit;
         if (emit) begin
            out_y       <= blk_ch[0];
            out_cb      <= blk_ch[1];
            out_cr      <= blk_ch[2];
            out_k       <= blk_ch[3];
            out_cosited <= pix_cos;
         end
      end
   end

   // R2: no pixel is presented without an established alignment
   a_r2_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> lock_q);

   // R8: a blanked pixel carries the levels that were held when it completed
   a_r8_blank_levels: assert property (@(posedge clk) disable iff (!rst_n)
      (emit && blank_req) |=> (out_y == $past(lvl_ch[0]) && out_cb == $past(lvl_ch[1])
                               && out_cr == $past(lvl_ch[2]) && out_k == $past(lvl_ch[3])));

   // R7: a realigning edge word never completes a pixel
   a_r7_edge_no_pixel: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && mode != MODE_PAR) |=> !out_valid);

endmodule

// File: tb/video_demux_tb.sv
module video_demux_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       par_in, one_link, full_chroma, cb_sync, blank_req, lvl_we;
   logic [9:0] din_a, din_b, din_c, din_d;
   logic [9:0] lvl_y, lvl_cb, lvl_cr, lvl_k;
   logic       out_valid, out_cosited;
   logic [9:0] out_y, out_cb, out_cr, out_k;

   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   video_demux u_dut (
      .clk(clk), .rst_n(rst_n), .par_in(par_in), .one_link(one_link),
      .full_chroma(full_chroma), .cb_sync(cb_sync), .blank_req(blank_req),
      .din_a(din_a), .din_b(din_b), .din_c(din_c), .din_d(din_d),
      .lvl_we(lvl_we), .lvl_y(lvl_y), .lvl_cb(lvl_cb), .lvl_cr(lvl_cr), .lvl_k(lvl_k),
      .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr),
      .out_k(out_k), .out_cosited(out_cosited)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_pix(input string tag, input int y, input int cb, input int cr,
                          input int k, input int cos);
      chk({tag, " valid"}, out_valid, 1);
      chk({tag, " y"},     out_y, y);
      chk({tag, " cb"},    out_cb, cb);
      chk({tag, " cr"},    out_cr, cr);
      chk({tag, " k"},     out_k, k);
      chk({tag, " cosited"}, out_cosited, cos);
   endtask

   // apply one word; returns 1 time unit after the edge that sampled it
   task automatic step(input int a, input int b, input int c, input int d,
                       input logic sync, input logic blank);
      din_a = 10'(a); din_b = 10'(b); din_c = 10'(c); din_d = 10'(d);
      cb_sync = sync; blank_req = blank;
      @(posedge clk); #1;
   endtask

   task automatic do_reset(input logic par, input logic one, input logic full);
      rst_n = 1'b0; par_in = par; one_link = one; full_chroma = full;
      cb_sync = 1'b0; blank_req = 1'b0; lvl_we = 1'b0;
      din_a = '0; din_b = '0; din_c = '0; din_d = '0;
      lvl_y = '0; lvl_cb = '0; lvl_cr = '0; lvl_k = '0;
      @(posedge clk); @(posedge clk); #1;
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      do_reset(1'b0, 1'b0, 1'b0);
      chk("R2 reset valid", out_valid, 0);
      chk("R2 reset y", out_y, 0);
      chk("R2 reset cb", out_cb, 0);
      chk("R2 reset k", out_k, 0);
   endtask

   task automatic t_presync_discard();
      do_reset(1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 8; i++) begin
         step(100 + i, 300 + i, 0, 0, 1'b0, 1'b0);
         chk("R2 pre-sync low", out_valid, 0);
      end
      for (int i = 0; i < 4; i++) begin
         step(200 + i, 400 + i, 0, 0, 1'b1, 1'b0);
         chk("R2 pre-sync high", out_valid, 0);
      end
   endtask

   task automatic t_dual_422();
      do_reset(1'b0, 1'b0, 1'b0);
      step(0, 0, 0, 0, 1'b1, 1'b0);
      step(100, 900, 0, 0, 1'b0, 1'b0);
      chk("R3 dual after Cb", out_valid, 0);
      step(200, 300, 0, 0, 1'b0, 1'b0);
      chk("R3 dual after Y0", out_valid, 0);
      step(400, 901, 0, 0, 1'b0, 1'b0);
      chk_pix("R3 dual first pixel", 200, 100, 400, 300, 1);
      step(250, 350, 0, 0, 1'b0, 1'b0);
      chk_pix("R4 dual repeated chroma", 250, 100, 400, 350, 0);
      step(110, 902, 0, 0, 1'b0, 1'b0);
      chk("R7 held low next group Cb", out_valid, 0);
      step(210, 310, 0, 0, 1'b0, 1'b0);
      step(410, 903, 0, 0, 1'b0, 1'b0);
      chk_pix("R7 held low second group", 210, 110, 410, 310, 1);
      step(260, 360, 0, 0, 1'b0, 1'b0);
      chk_pix("R4 dual second group repeat", 260, 110, 410, 360, 0);
   endtask

   task automatic t_dual_444();
      do_reset(1'b0, 1'b0, 1'b1);
      step(0, 0, 0, 0, 1'b1, 1'b0);
      step(120, 121, 0, 0, 1'b0, 1'b0);
      step(220, 320, 0, 0, 1'b0, 1'b0);
      step(420, 421, 0, 0, 1'b0, 1'b0);
      chk_pix("R3 dual444 first", 220, 120, 420, 320, 1);
      step(270, 370, 0, 0, 1'b0, 1'b0);
      chk_pix("R4 dual444 link B chroma", 270, 121, 421, 370, 1);
   endtask

   task automatic t_single();
      do_reset(1'b0, 1'b1, 1'b0);
      step(0, 0, 0, 0, 1'b1, 1'b0);
      step(130, 777, 0, 0, 1'b0, 1'b0);
      chk("R5 single after Cb", out_valid, 0);
      step(230, 777, 0, 0, 1'b0, 1'b0);
      chk("R5 single after Y", out_valid, 0);
      step(430, 777, 0, 0, 1'b0, 1'b0);
      chk("R5 single after Cr", out_valid, 0);
      step(330, 777, 0, 0, 1'b0, 1'b0);
      chk_pix("R5 single pixel 1", 230, 130, 430, 330, 1);
      step(131, 0, 0, 0, 1'b0, 1'b0);
      chk("R5 single gap", out_valid, 0);
      step(231, 0, 0, 0, 1'b0, 1'b0);
      step(431, 0, 0, 0, 1'b0, 1'b0);
      step(331, 0, 0, 0, 1'b0, 1'b0);
      chk_pix("R5 single pixel 2", 231, 131, 431, 331, 1);
   endtask

   task automatic t_par();
      do_reset(1'b1, 1'b0, 1'b0);
      step(0, 0, 0, 0, 1'b1, 1'b0);
      chk("R6 par before sync", out_valid, 0);
      step(240, 140, 440, 340, 1'b0, 1'b0);
      chk_pix("R1 R6 par even", 240, 140, 440, 340, 1);
      step(241, 999, 999, 341, 1'b0, 1'b0);
      chk_pix("R6 par odd carried chroma", 241, 140, 440, 341, 0);
      step(242, 142, 442, 342, 1'b0, 1'b0);
      chk_pix("R6 par next even", 242, 142, 442, 342, 1);
      // one_link set high must not change the non-multiplexed decode
      do_reset(1'b1, 1'b1, 1'b1);
      step(0, 0, 0, 0, 1'b1, 1'b0);
      step(250, 150, 450, 350, 1'b0, 1'b0);
      chk_pix("R1 par dominates one_link", 250, 150, 450, 350, 1);
      step(251, 151, 451, 351, 1'b0, 1'b0);
      chk_pix("R6 par odd own chroma", 251, 151, 451, 351, 1);
   endtask

   task automatic t_resync();
      do_reset(1'b0, 1'b0, 1'b0);
      step(0, 0, 0, 0, 1'b1, 1'b0);
      step(100, 0, 0, 0, 1'b0, 1'b0);
      step(200, 300, 0, 0, 1'b0, 1'b0);
      step(555, 0, 0, 0, 1'b1, 1'b0);
      step(150, 0, 0, 0, 1'b0, 1'b0);
      chk("R7 realign on new edge", out_valid, 0);
      step(250, 350, 0, 0, 1'b0, 1'b0);
      chk("R7 old phase abandoned", out_valid, 0);
      step(450, 0, 0, 0, 1'b0, 1'b0);
      chk_pix("R7 first pixel after realign", 250, 150, 450, 350, 1);
   endtask

   task automatic t_blank();
      do_reset(1'b0, 1'b0, 1'b0);
      step(0, 0, 0, 0, 1'b1, 1'b0);
      step(100, 0, 0, 0, 1'b0, 1'b0);
      step(200, 300, 0, 0, 1'b0, 1'b0);
      // load new levels in the very cycle a pixel is blanked
      lvl_y = 10'd16; lvl_cb = 10'd400; lvl_cr = 10'd600; lvl_k = 10'd940; lvl_we = 1'b1;
      step(400, 0, 0, 0, 1'b0, 1'b1);
      lvl_we = 1'b0;
      chk_pix("R9 R8 default levels, load same cycle", 64, 512, 512, 64, 1);
      step(250, 350, 0, 0, 1'b0, 1'b0);
      chk_pix("R8 blank low passes", 250, 100, 400, 350, 0);
      step(110, 0, 0, 0, 1'b0, 1'b1);
      step(210, 310, 0, 0, 1'b0, 1'b1);
      step(410, 0, 0, 0, 1'b0, 1'b1);
      chk_pix("R9 loaded levels", 16, 400, 600, 940, 1);
      step(260, 360, 0, 0, 1'b0, 1'b1);
      chk_pix("R8 blank keeps cosited flag", 16, 400, 600, 940, 0);
   endtask

   initial begin
      t_reset_state();
      t_presync_discard();
      t_dual_422();
      t_dual_444();
      t_single();
      t_par();
      t_resync();
      t_blank();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule